// File: doc/BRIEF.md
# Floating-Point Register Stack with Exchange

This block holds the eight working registers of a stack-organised floating-point unit, 80 bits each, together with a per-register empty tag and a 3-bit top-of-stack pointer. All register references are relative to that pointer: position ST(i) lives in physical slot (TOP + i) mod 8. The block accepts one operation per cycle: push a value, pop the top, or exchange ST(0) with ST(i). The exchange is selected by a two-byte opcode: escape byte 0xD9 followed by 0xC8 + i.

The block checks availability and pending-fault conditions before it changes any state. An exchange that touches an empty register is a stack underflow. It sets the invalid-operation and stack-fault status bits. If the invalid-operation exception is masked, the empty operand is filled with the negative quiet NaN (real indefinite) before the swap. If the exception is unmasked, the registers are left alone. Arithmetic and memory transfers sit outside this block. They read the stack through the relative read port.

Top module: `fpstk_top`

## Requirements
- R1: After reset, TOP is 0, all eight tags read empty, C1, IE and SF are 0, and the three fault outputs are 0.
- R2: The read port returns the register and tag at physical slot (TOP + rd_idx) mod 8, so after pushing A, B and C in turn, ST(0)=C, ST(1)=B and ST(2)=A.
- R3: An executed push (op_kind=1) decrements TOP modulo 8, writes push_data into the new ST(0) and marks it non-empty. From reset, TOP becomes 7.
- R4: An executed pop (op_kind=2) marks ST(0) empty and then increments TOP modulo 8.
- R5: An executed exchange (op_kind=3) with opcode 0xD9, 0xC8+i swaps ST(0) and ST(i). Opcode 0xD9C9 is the default form and uses ST(1). 0xD9C8 leaves the stack unchanged. Every executed exchange clears C1.
- R6: An executed exchange in which ST(0) or ST(i) is empty sets both IE and SF. Both bits stay set until reset, and SF is never set without IE.
- R7: On underflow with im_mask=1, each empty operand is first replaced by 0xFFFF_C000_0000_0000_0000 and then the swap is made. Both slots end up non-empty.
- R8: On underflow with im_mask=0, all register contents and tags are left unchanged.
- R9: An operation presented with cr_em or cr_ts set is not executed. nm_flt pulses high in the following cycle, and this fault takes priority over exc_pend.
- R10: An operation presented with cr_em and cr_ts clear and exc_pend set is not executed. mf_flt pulses high in the following cycle.
- R11: An exchange whose opcode is not 0xD9 followed by a byte in 0xC8..0xCF is not executed. ill_flt pulses high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 2 | 0 none, 1 push, 2 pop, 3 exchange |
| opcode | input | 16 | Exchange opcode, escape byte in bits 15:8 |
| push_data | input | 80 | Value written by a push |
| im_mask | input | 1 | Invalid-operation exception masked |
| cr_em | input | 1 | Emulation control bit |
| cr_ts | input | 1 | Task-switched control bit |
| exc_pend | input | 1 | An unmasked exception is pending |
| rd_idx | input | 3 | Relative index i of the read port |
| rd_data | output | 80 | Contents of ST(rd_idx) |
| rd_empty | output | 1 | Tag of ST(rd_idx) |
| top_o | output | 3 | Top-of-stack pointer |
| c1_o | output | 1 | Condition bit C1 |
| ie_o | output | 1 | Invalid-operation status, sticky |
| sf_o | output | 1 | Stack-fault status, sticky |
| nm_flt | output | 1 | Device-not-available fault pulse |
| mf_flt | output | 1 | Pending-exception fault pulse |
| ill_flt | output | 1 | Undecodable exchange opcode pulse |

## Verification
The checker assumes that op_kind, opcode, push_data and the gating inputs are stable around each rising edge. It also assumes that rd_idx is 0 whenever it compares the read port against the previous push. The bench drives every input on the falling edge and returns rd_idx to 0 before it presents an operation. Operations are issued with gaps between them, and each one is checked through the relative read port after its edge. No operation overlaps a read-back of the previous one.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
   typedef enum logic [1:0] {
      STK_NONE = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2,
      STK_XCH  = 2'd3
   } stk_op_e;

   // negative quiet NaN used to fill empty operands on masked underflow
   localparam logic [79:0] STK_INDEF = 80'hFFFF_C000_0000_0000_0000;
endpackage

// File: rtl/fpstk_decode.sv
module fpstk_decode #(
   parameter int          PTR_W    = 3,
   parameter logic [7:0]  ESC_BYTE = 8'hD9,
   parameter logic [7:0]  XCH_BASE = 8'hC8
) (
   input  logic [15:0]      opcode,
   output logic             dec_ok,
   output logic [PTR_W-1:0] dec_idx
);
   localparam logic [7:0] IDX_MASK = 8'((1 << PTR_W) - 1);

   generate
      if ((XCH_BASE & IDX_MASK) != 8'h00) begin : g_bad_base
         $error("XCH_BASE must have its index bits clear");
      end
   endgenerate

   always_comb begin
      dec_ok  = (opcode[15:8] == ESC_BYTE) && ((opcode[7:0] & ~IDX_MASK) == XCH_BASE);
      dec_idx = opcode[PTR_W-1:0];
   end
endmodule

// File: rtl/fpstk_entry.sv
module fpstk_entry #(
   parameter int WIDTH = 80
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             free,
   output logic [WIDTH-1:0] q,
   output logic             empty
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= '0;
         empty <= 1'b1;
      end else if (wr_en) begin
         q     <= wr_data;
         empty <= 1'b0;
      end else if (free) begin
         empty <= 1'b1;
      end
   end
endmodule

// File: rtl/fpstk_top.sv
module fpstk_top
   import fpstk_pkg::*;
#(
   parameter int               WIDTH    = 80,
   parameter int               DEPTH    = 8,
   parameter logic [7:0]       ESC_BYTE = 8'hD9,
   parameter logic [7:0]       XCH_BASE = 8'hC8,
   parameter bit               READ_REG = 1'b0,
   parameter logic [WIDTH-1:0] INDEF    = STK_INDEF,
   localparam int              PTR_W    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [1:0]       op_kind,
   input  logic [15:0]      opcode,
   input  logic [WIDTH-1:0] push_data,
   input  logic             im_mask,
   input  logic             cr_em,
   input  logic             cr_ts,
   input  logic             exc_pend,
   input  logic [PTR_W-1:0] rd_idx,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_empty,
   output logic [PTR_W-1:0] top_o,
   output logic             c1_o,
   output logic             ie_o,
   output logic             sf_o,
   output logic             nm_flt,
   output logic             mf_flt,
   output logic             ill_flt
);
   generate
      if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (PTR_W > 8) begin : g_bad_ptr
         $error("DEPTH too large for an opcode index");
      end
   endgenerate

   stk_op_e          op_e;
   logic             blk_nm, blk_mf, go;
   logic             push_go, pop_go, xch_try, xch_go, xch_bad, xch_wr, under;
   logic             dec_ok;
   logic [PTR_W-1:0] dec_idx;
   logic [PTR_W-1:0] top_q, push_slot, pa, pb, rd_phys;
   logic             c1_q, ie_q, sf_q, nm_q, mf_q, ill_q;
   logic             ea, eb;
   logic [WIDTH-1:0] va, vb;
   logic [WIDTH-1:0] ent_q [DEPTH];
   logic [DEPTH-1:0] ent_empty;

   assign op_e = stk_op_e'(op_kind);

   // gating: availability first, then pending exception
   always_comb begin
      blk_nm  = op_valid && (cr_em || cr_ts);
      blk_mf  = op_valid && !blk_nm && exc_pend;
      go      = op_valid && !cr_em && !cr_ts && !exc_pend;
      push_go = go && (op_e == STK_PUSH);
      pop_go  = go && (op_e == STK_POP);
      xch_try = go && (op_e == STK_XCH);
   end

   fpstk_decode #(
      .PTR_W    (PTR_W),
      .ESC_BYTE (ESC_BYTE),
      .XCH_BASE (XCH_BASE)
   ) dec_i (
      .opcode  (opcode),
      .dec_ok  (dec_ok),
      .dec_idx (dec_idx)
   );

   always_comb begin
      xch_go    = xch_try && dec_ok;
      xch_bad   = xch_try && !dec_ok;
      push_slot = top_q - PTR_W'(1);
      pa        = top_q;
      pb        = top_q + dec_idx;
      ea        = ent_empty[pa];
      eb        = ent_empty[pb];
      under     = xch_go && (ea || eb);
      xch_wr    = xch_go && (!under || im_mask);
      va        = ea ? INDEF : ent_q[pa];
      vb        = eb ? INDEF : ent_q[pb];
   end

   genvar k;
   generate
      for (k = 0; k < DEPTH; k++) begin : g_ent
         logic             hit_push, hit_a, hit_b, hit_free;
         logic [WIDTH-1:0] wd;
         always_comb begin
            hit_push = push_go && (push_slot == PTR_W'(k));
            hit_a    = xch_wr && (pa == PTR_W'(k));
            hit_b    = xch_wr && (pb == PTR_W'(k));
            hit_free = pop_go && (top_q == PTR_W'(k));
            if (hit_push)   wd = push_data;
            else if (hit_a) wd = vb;
            else            wd = va;
         end
         fpstk_entry #(.WIDTH(WIDTH)) ent_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (hit_push || hit_a || hit_b),
            .wr_data (wd),
            .free    (hit_free),
            .q       (ent_q[k]),
            .empty   (ent_empty[k])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q <= '0;
         c1_q  <= 1'b0;
         ie_q  <= 1'b0;
         sf_q  <= 1'b0;
         nm_q  <= 1'b0;
         mf_q  <= 1'b0;
         ill_q <= 1'b0;
      end else begin
         if (push_go)     top_q <= top_q - PTR_W'(1);
         else if (pop_go) top_q <= top_q + PTR_W'(1);
         if (xch_go) c1_q <= 1'b0;
         if (under) begin
            ie_q <= 1'b1;
            sf_q <= 1'b1;
         end
         nm_q  <= blk_nm;
         mf_q  <= blk_mf;
         ill_q <= xch_bad;
      end
   end

   assign rd_phys = top_q + rd_idx;

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_data  <= '0;
               rd_empty <= 1'b1;
            end else begin
               rd_data  <= ent_q[rd_phys];
               rd_empty <= ent_empty[rd_phys];
            end
         end
      end else begin : g_rd_comb
         always_comb begin
            rd_data  = ent_q[rd_phys];
            rd_empty = ent_empty[rd_phys];
         end
      end
   endgenerate

   assign top_o   = top_q;
   assign c1_o    = c1_q;
   assign ie_o    = ie_q;
   assign sf_o    = sf_q;
   assign nm_flt  = nm_q;
   assign mf_flt  = mf_q;
   assign ill_flt = ill_q;
endmodule

// File: rtl/fpstk_chk.sv
module fpstk_chk #(
   parameter int WIDTH    = 80,
   parameter int PTR_W    = 3,
   parameter bit READ_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [1:0]       op_kind,
   input logic [15:0]      opcode,
   input logic [WIDTH-1:0] push_data,
   input logic             cr_em,
   input logic             cr_ts,
   input logic             exc_pend,
   input logic [PTR_W-1:0] rd_idx,
   input logic [WIDTH-1:0] rd_data,
   input logic             rd_empty,
   input logic [PTR_W-1:0] top_o,
   input logic             c1_o,
   input logic             ie_o,
   input logic             sf_o,
   input logic             nm_flt,
   input logic             mf_flt,
   input logic             ill_flt
);
   logic acc, xch_ok;
   assign acc    = op_valid && !cr_em && !cr_ts && !exc_pend;
   assign xch_ok = (opcode[15:8] == 8'hD9) && (opcode[7:3] == 5'b11001);

   AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_kind == 2'd1 |=> top_o == $past(top_o) - PTR_W'(1)); // R3
   AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !READ_REG && acc && op_kind == 2'd1 |=> rd_idx != '0 || (rd_data == $past(push_data) && !rd_empty)); // R3
   AST_POP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_kind == 2'd2 |=> top_o == $past(top_o) + PTR_W'(1)); // R4
   AST_XCH_C1: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_kind == 2'd3 && xch_ok |=> !c1_o); // R5
   AST_IE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ie_o |=> ie_o); // R6
   AST_SF_WITH_IE: assert property (@(posedge clk) disable iff (!rst_n)
      sf_o |-> ie_o); // R6
   AST_NM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (cr_em || cr_ts) |=> nm_flt && !mf_flt && $stable(top_o)); // R9
   AST_MF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !cr_em && !cr_ts && exc_pend |=> mf_flt && !nm_flt && $stable(top_o)); // R10
   AST_ILL_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
      acc && op_kind == 2'd3 && !xch_ok |=> ill_flt && $stable(top_o) && $stable(ie_o)); // R11
   AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nm_flt, mf_flt, ill_flt})); // R9
endmodule

bind fpstk_top fpstk_chk #(
   .WIDTH    (WIDTH),
   .PTR_W    (PTR_W),
   .READ_REG (READ_REG)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_kind   (op_kind),
   .opcode    (opcode),
   .push_data (push_data),
   .cr_em     (cr_em),
   .cr_ts     (cr_ts),
   .exc_pend  (exc_pend),
   .rd_idx    (rd_idx),
   .rd_data   (rd_data),
   .rd_empty  (rd_empty),
   .top_o     (top_o),
   .c1_o      (c1_o),
   .ie_o      (ie_o),
   .sf_o      (sf_o),
   .nm_flt    (nm_flt),
   .mf_flt    (mf_flt),
   .ill_flt   (ill_flt)
);

// File: tb/fpstk_top_tb_top.sv
module fpstk_top_tb_top;
   localparam logic [79:0] INDEF = 80'hFFFF_C000_0000_0000_0000;
   localparam logic [79:0] VA = 80'h3FFF_8000_0000_0000_0000;
   localparam logic [79:0] VB = 80'h4000_C000_0000_0000_0001;
   localparam logic [79:0] VC = 80'hC001_A000_0000_0000_0002;
   localparam logic [79:0] VD = 80'h4005_F000_0000_0000_0003;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_kind = 2'd0;
   logic [15:0] opcode = 16'h0;
   logic [79:0] push_data = '0;
   logic        im_mask = 1'b1;
   logic        cr_em = 1'b0;
   logic        cr_ts = 1'b0;
   logic        exc_pend = 1'b0;
   logic [2:0]  rd_idx = 3'd0;
   logic [79:0] rd_data;
   logic        rd_empty;
   logic [2:0]  top_o;
   logic        c1_o, ie_o, sf_o, nm_flt, mf_flt, ill_flt;

   int n_chk = 0;
   int n_err = 0;
   logic nm_s, mf_s, ill_s;

   always #5 clk = ~clk;

   fpstk_top dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .opcode(opcode), .push_data(push_data), .im_mask(im_mask),
      .cr_em(cr_em), .cr_ts(cr_ts), .exc_pend(exc_pend), .rd_idx(rd_idx),
      .rd_data(rd_data), .rd_empty(rd_empty), .top_o(top_o), .c1_o(c1_o),
      .ie_o(ie_o), .sf_o(sf_o), .nm_flt(nm_flt), .mf_flt(mf_flt), .ill_flt(ill_flt)
   );

   task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; op_valid = 1'b0; im_mask = 1'b1;
      cr_em = 1'b0; cr_ts = 1'b0; exc_pend = 1'b0; rd_idx = 3'd0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_op(input logic [1:0] k, input logic [15:0] opc, input logic [79:0] d);
      @(negedge clk);
      rd_idx = 3'd0; op_valid = 1'b1; op_kind = k; opcode = opc; push_data = d;
      @(negedge clk);
      op_valid = 1'b0;
      nm_s = nm_flt; mf_s = mf_flt; ill_s = ill_flt;
   endtask

   task automatic rd(input logic [2:0] i, output logic [79:0] d, output logic e);
      rd_idx = i;
      #1;
      d = rd_data;
      e = rd_empty;
      rd_idx = 3'd0;
   endtask

   task automatic t_reset();
      logic [79:0] d; logic e;
      do_reset();
      chk("R1 top", 80'(top_o), 80'd0);
      chk("R1 status", {77'd0, c1_o, ie_o, sf_o}, 80'd0);
      chk("R1 faults", {77'd0, nm_flt, mf_flt, ill_flt}, 80'd0);
      for (int i = 0; i < 8; i++) begin
         rd(3'(i), d, e);
         chk("R1 tag empty", 80'(e), 80'd1);
      end
   endtask

   task automatic t_push_read();
      logic [79:0] d; logic e;
      do_reset();
      do_op(2'd1, 16'h0, VA);
      chk("R3 top wraps to 7", 80'(top_o), 80'd7);
      rd(3'd0, d, e);
      chk("R3 data", d, VA);
      chk("R3 tag valid", 80'(e), 80'd0);
      do_op(2'd1, 16'h0, VB);
      do_op(2'd1, 16'h0, VC);
      rd(3'd0, d, e); chk("R2 ST0", d, VC);
      rd(3'd1, d, e); chk("R2 ST1", d, VB);
      rd(3'd2, d, e); chk("R2 ST2", d, VA);
      rd(3'd3, d, e); chk("R2 ST3 empty", 80'(e), 80'd1);
   endtask

   task automatic t_pop();
      logic [79:0] d; logic e;
      do_reset();
      do_op(2'd1, 16'h0, VA);
      do_op(2'd1, 16'h0, VB);
      do_op(2'd2, 16'h0, '0);
      chk("R4 top", 80'(top_o), 80'd7);
      rd(3'd0, d, e); chk("R4 new ST0", d, VA);
      rd(3'd7, d, e); chk("R4 freed slot empty", 80'(e), 80'd1);
      chk("R4 no underflow", 80'(ie_o), 80'd0);
   endtask

   task automatic t_xch_default();
      logic [79:0] d; logic e;
      do_reset();
      do_op(2'd1, 16'h0, VA);
      do_op(2'd1, 16'h0, VB);
      do_op(2'd3, 16'hD9C9, '0);
      rd(3'd0, d, e); chk("R5 default ST0", d, VA);
      rd(3'd1, d, e); chk("R5 default ST1", d, VB);
      chk("R5 C1 clear", 80'(c1_o), 80'd0);
      chk("R5 no IE", 80'({ie_o, sf_o}), 80'd0);
      do_op(2'd3, 16'hD9C8, '0);
      rd(3'd0, d, e); chk("R5 self exchange", d, VA);
      chk("R5 top unchanged", 80'(top_o), 80'd6);
   endtask

   task automatic t_xch_idx();
      logic [79:0] d; logic e;
      do_reset();
      do_op(2'd1, 16'h0, VA);
      do_op(2'd1, 16'h0, VB);
      do_op(2'd1, 16'h0, VC);
      do_op(2'd1, 16'h0, VD);
      do_op(2'd3, 16'hD9CB, '0);
      rd(3'd0, d, e); chk("R5 ST0 after ST3 swap", d, VA);
      rd(3'd3, d, e); chk("R5 ST3 after swap", d, VD);
      rd(3'd1, d, e); chk("R5 ST1 untouched", d, VC);
   endtask

   task automatic t_under_masked();
      logic [79:0] d; logic e;
      do_reset();
      im_mask = 1'b1;
      do_op(2'd1, 16'h0, VA);
      do_op(2'd3, 16'hD9C9, '0);
      rd(3'd0, d, e); chk("R7 ST0 indefinite", d, INDEF);
      chk("R7 ST0 valid", 80'(e), 80'd0);
      rd(3'd1, d, e); chk("R7 ST1 got old ST0", d, VA);
      chk("R7 ST1 valid", 80'(e), 80'd0);
      chk("R6 IE SF set", 80'({ie_o, sf_o}), 80'd3);
      do_op(2'd3, 16'hD9C9, '0);
      chk("R6 IE SF sticky", 80'({ie_o, sf_o}), 80'd3);
   endtask

   task automatic t_under_unmasked();
      logic [79:0] d; logic e;
      do_reset();
      im_mask = 1'b0;
      do_op(2'd1, 16'h0, VA);
      do_op(2'd3, 16'hD9CA, '0);
      chk("R6 IE SF set unmasked", 80'({ie_o, sf_o}), 80'd3);
      rd(3'd0, d, e); chk("R8 ST0 kept", d, VA);
      chk("R8 ST0 tag kept", 80'(e), 80'd0);
      rd(3'd2, d, e); chk("R8 ST2 still empty", 80'(e), 80'd1);
      im_mask = 1'b1;
   endtask

   task automatic t_gating();
      logic [79:0] d; logic e;
      do_reset();
      do_op(2'd1, 16'h0, VA);
      cr_em = 1'b1;
      do_op(2'd1, 16'h0, VB);
      chk("R9 nm on EM", 80'(nm_s), 80'd1);
      chk("R9 top kept", 80'(top_o), 80'd7);
      rd(3'd0, d, e); chk("R9 ST0 kept", d, VA);
      cr_em = 1'b0; cr_ts = 1'b1;
      do_op(2'd2, 16'h0, '0);
      chk("R9 nm on TS", 80'(nm_s), 80'd1);
      rd(3'd0, d, e); chk("R9 pop blocked", 80'(e), 80'd0);
      exc_pend = 1'b1;
      do_op(2'd2, 16'h0, '0);
      chk("R9 nm priority over mf", 80'({nm_s, mf_s}), 80'd2);
      cr_ts = 1'b0;
      do_op(2'd3, 16'hD9C9, '0);
      chk("R10 mf pulse", 80'({nm_s, mf_s}), 80'd1);
      chk("R10 no underflow", 80'(ie_o), 80'd0);
      exc_pend = 1'b0;
      @(negedge clk);
      chk("R10 pulse one cycle", 80'(mf_flt), 80'd0);
   endtask

   task automatic t_illegal();
      logic [79:0] d; logic e;
      do_reset();
      do_op(2'd1, 16'h0, VA);
      do_op(2'd1, 16'h0, VB);
      do_op(2'd3, 16'hD9D1, '0);
      chk("R11 ill second byte", 80'(ill_s), 80'd1);
      rd(3'd0, d, e); chk("R11 no swap", d, VB);
      do_op(2'd3, 16'hDDC9, '0);
      chk("R11 ill escape", 80'(ill_s), 80'd1);
      rd(3'd1, d, e); chk("R11 ST1 kept", d, VA);
      do_op(2'd3, 16'hD9C9, '0);
      chk("R11 good opcode no ill", 80'(ill_s), 80'd0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL WATCHDOG: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_push_read();
      t_pop();
      t_xch_default();
      t_xch_idx();
      t_under_masked();
      t_under_unmasked();
      t_gating();
      t_illegal();
      summary();
      $finish;
   end
endmodule